// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block divides a fast clock (a digital stand-in for the oscillator signal a frequency synthesizer feeds back) by an integer N and emits one pulse per N input clocks, for use as the feedback edge of a phase detector. A dual-modulus prescaler divides by either P or P+1. A swallow count A sets how many prescaler cycles use P+1 in each output period, and a main count B sets how many prescaler cycles make up the period. The result is N = P·B + A.

The prescaler base P is chosen by one pin: 64 or 128. Out-of-range settings are clamped inside the block rather than rejected. B below 3 is treated as 3. A is limited to the smaller of P and the clamped B. A counter-reset pin holds every counter at the start of a period. A power-down pin freezes the counters exactly where they are. All pins are plain control and status levels. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `pulse_swallow_div`

## Requirements
- R1: With settings held steady, successive output pulses are exactly P·B + A enabled clocks apart, using the clamped values of A and B.
- R2: `mode_hi` = 0 selects P = 64, and `mode_hi` = 1 selects P = 128.
- R3: A `main_b` value of 0, 1 or 2 divides exactly as B = 3 would.
- R4: A `swallow_a` value above min(P, clamped B) divides exactly as A = min(P, clamped B) would. A equal to B is a legal setting.
- R5: While `cnt_reset` is 1, no pulse is produced. After `cnt_reset` falls, the first pulse appears after exactly P·B + A enabled clocks.
- R6: While `pdn` is 1, no pulse is produced and the count is frozen. After `pdn` falls, counting continues from the frozen point, so enabled clocks before and after the pause add up to P·B + A.
- R7: Each output pulse is high for exactly one clock.
- R8: While `rst_n` is 0, `div_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_reset | input | 1 | Holds all counters at period start while 1 |
| pdn | input | 1 | Freezes all counters while 1 |
| mode_hi | input | 1 | Prescaler base select: 0 gives 64, 1 gives 128 |
| swallow_a | input | 7 | Swallow count A |
| main_b | input | 11 | Main count B |
| div_pulse | output | 1 | One-clock pulse marking the end of each divided period |

## Verification
The pulse is registered. It rises on the same clock edge that completes the N-th enabled clock after a period starts, and it falls on the next edge. The bench drives inputs and samples outputs on falling edges. It counts enabled clocks from the falling edge at which `cnt_reset` or `pdn` is released, so a correct design shows the first pulse at a count of exactly N, the pulse low again one sample later, and the next pulse N samples after the first. A count that is off by one fails the exact comparison. The bound checker keeps its own enabled-clock count from the ports and requires each pulse to land exactly on the expected count.

// File: rtl/pls_pkg.sv
package pls_pkg;
  // prescaler base selection
  typedef enum logic {
    MOD_LO = 1'b0,
    MOD_HI = 1'b1
  } pmod_e;
endpackage

// File: rtl/pls_limit.sv
module pls_limit #(
  parameter int A_W   = 7,
  parameter int B_W   = 11,
  parameter int P_LO  = 64,
  parameter int P_HI  = 128,
  parameter int B_MIN = 3
) (
  input  pls_pkg::pmod_e   sel,
  input  logic [A_W-1:0]   a_in,
  input  logic [B_W-1:0]   b_in,
  output logic [A_W-1:0]   a_eff,
  output logic [B_W-1:0]   b_eff
);
  localparam int LW = B_W + 1;

  logic [LW-1:0] base;
  logic [LW-1:0] b_wide;
  logic [LW-1:0] a_wide;
  logic [LW-1:0] a_lim;

  always_comb begin
    b_eff  = (b_in < B_W'(B_MIN)) ? B_W'(B_MIN) : b_in;
    base   = (sel == pls_pkg::MOD_HI) ? LW'(P_HI) : LW'(P_LO);
    b_wide = {1'b0, b_eff};
    a_wide = {{(LW-A_W){1'b0}}, a_in};
    a_lim  = (base < b_wide) ? base : b_wide;
    a_eff  = (a_wide > a_lim) ? a_lim[A_W-1:0] : a_in;
  end
endmodule

// File: rtl/pls_prescaler.sv
module pls_prescaler #(
  parameter int P_LO = 64,
  parameter int P_HI = 128
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           run,
  input  pls_pkg::pmod_e sel,
  input  logic           plus1,
  output logic           wrap
);
  localparam int PW = $clog2(P_HI + 1);

  logic [PW-1:0] pcnt;
  logic [PW-1:0] last;

  always_comb begin
    last = (sel == pls_pkg::MOD_HI) ? PW'(P_HI - 1) : PW'(P_LO - 1);
    if (plus1) last = last + PW'(1);
  end

  assign wrap = run && (pcnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcnt <= '0;
    else if (clr)    pcnt <= '0;
    else if (run)    pcnt <= wrap ? '0 : pcnt + PW'(1);
  end
endmodule

// File: rtl/pls_counters.sv
module pls_counters #(
  parameter int A_W = 7,
  parameter int B_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           wrap,
  input  logic [A_W-1:0] a_eff,
  input  logic [B_W-1:0] b_eff,
  output logic           a_nz,
  output logic           pulse
);
  logic [A_W-1:0] a_idx;
  logic [B_W-1:0] b_idx;
  logic           term;

  // swallow cycles still owed in this period
  assign a_nz = a_idx < a_eff;
  // last prescaler cycle of the period
  assign term = b_idx >= (b_eff - B_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_idx <= '0;
      b_idx <= '0;
      pulse <= 1'b0;
    end else if (clr) begin
      a_idx <= '0;
      b_idx <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= wrap && term;
      if (wrap) begin
        if (term) begin
          a_idx <= '0;
          b_idx <= '0;
        end else begin
          b_idx <= b_idx + B_W'(1);
          if (a_nz) a_idx <= a_idx + A_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
  parameter int A_W   = 7,
  parameter int B_W   = 11,
  parameter int P_LO  = 64,
  parameter int P_HI  = 128,
  parameter int B_MIN = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cnt_reset,
  input  logic           pdn,
  input  logic           mode_hi,
  input  logic [A_W-1:0] swallow_a,
  input  logic [B_W-1:0] main_b,
  output logic           div_pulse
);
  pls_pkg::pmod_e sel;
  logic [A_W-1:0] a_eff;
  logic [B_W-1:0] b_eff;
  logic           run;
  logic           wrap;
  logic           a_nz;

  assign sel = pls_pkg::pmod_e'(mode_hi);
  assign run = !cnt_reset && !pdn;

  pls_limit #(.A_W(A_W), .B_W(B_W), .P_LO(P_LO), .P_HI(P_HI), .B_MIN(B_MIN)) u_lim (
    .sel(sel), .a_in(swallow_a), .b_in(main_b), .a_eff(a_eff), .b_eff(b_eff)
  );

  pls_prescaler #(.P_LO(P_LO), .P_HI(P_HI)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(cnt_reset), .run(run),
    .sel(sel), .plus1(a_nz), .wrap(wrap)
  );

  pls_counters #(.A_W(A_W), .B_W(B_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_reset), .wrap(wrap),
    .a_eff(a_eff), .b_eff(b_eff), .a_nz(a_nz), .pulse(div_pulse)
  );
endmodule

// File: rtl/pls_div_chk.sv
module pls_div_chk #(
  parameter int A_W   = 7,
  parameter int B_W   = 11,
  parameter int P_LO  = 64,
  parameter int P_HI  = 128,
  parameter int B_MIN = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cnt_reset,
  input logic           pdn,
  input logic           mode_hi,
  input logic [A_W-1:0] swallow_a,
  input logic [B_W-1:0] main_b,
  input logic           div_pulse
);
  localparam int NW = B_W + $clog2(P_HI) + 2;

  logic [NW-1:0] p_w, b_w, a_w, lim_w, a_e, n_exp, cyc;
  logic          en;

  assign en = !cnt_reset && !pdn;

  always_comb begin
    p_w   = mode_hi ? NW'(P_HI) : NW'(P_LO);
    b_w   = (main_b < B_W'(B_MIN)) ? NW'(B_MIN) : NW'(main_b);
    a_w   = NW'(swallow_a);
    lim_w = (p_w < b_w) ? p_w : b_w;
    a_e   = (a_w > lim_w) ? lim_w : a_w;
    n_exp = p_w * b_w + a_e;
  end

  // enabled clocks since the start of the current period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cyc <= '0;
    else if (cnt_reset) cyc <= '0;
    else if (div_pulse) cyc <= en ? NW'(1) : '0;
    else if (en)        cyc <= cyc + NW'(1);
  end

  a_r1_period: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> cyc == n_exp);
  a_r1_no_late: assert property (@(posedge clk) disable iff (!rst_n)
    cyc <= n_exp);
  a_r7_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_reset |=> !div_pulse);
  a_r6_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    pdn |=> !div_pulse);
endmodule

bind pulse_swallow_div pls_div_chk #(
  .A_W(A_W), .B_W(B_W), .P_LO(P_LO), .P_HI(P_HI), .B_MIN(B_MIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_reset(cnt_reset), .pdn(pdn),
  .mode_hi(mode_hi), .swallow_a(swallow_a), .main_b(main_b),
  .div_pulse(div_pulse)
);

// File: tb/sim_pulse_swallow_div.sv
module sim_pulse_swallow_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_reset = 1'b1;
  logic        pdn = 1'b0;
  logic        mode_hi = 1'b0;
  logic [6:0]  swallow_a = '0;
  logic [10:0] main_b = 11'd3;
  logic        div_pulse;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pulse_swallow_div u0 (
    .clk(clk), .rst_n(rst_n), .cnt_reset(cnt_reset), .pdn(pdn),
    .mode_hi(mode_hi), .swallow_a(swallow_a), .main_b(main_b),
    .div_pulse(div_pulse)
  );

  typedef struct packed {
    logic        hi;
    logic [6:0]  a;
    logic [10:0] b;
    logic [18:0] n;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 7'd0,   11'd3,   19'd192},   // R1 R2 smallest base-64 ratio
    '{1'b0, 7'd5,   11'd10,  19'd645},   // R1
    '{1'b1, 7'd3,   11'd4,   19'd515},   // R2 base 128
    '{1'b0, 7'd0,   11'd1,   19'd192},   // R3 B below minimum
    '{1'b0, 7'd100, 11'd200, 19'd12864}, // R4 A limited by P=64
    '{1'b1, 7'd100, 11'd50,  19'd6450},  // R4 A limited by B
    '{1'b0, 7'd3,   11'd3,   19'd195},   // R4 A equal to B
    '{1'b1, 7'd0,   11'd0,   19'd384},   // R3 R2 B zero, base 128
    '{1'b0, 7'd70,  11'd2,   19'd195}    // R3 R4 both clamps
  };
  string vtag [NV] = '{"R2", "R1", "R2", "R3", "R4", "R4", "R4", "R3", "R4"};

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!div_pulse && k < 400000);
  endtask

  task automatic load(logic hi, logic [6:0] a, logic [10:0] b);
    @(negedge clk);
    cnt_reset = 1'b1;
    mode_hi   = hi;
    swallow_a = a;
    main_b    = b;
    repeat (3) @(negedge clk);
    cnt_reset = 1'b0;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin : main
    int k;
    int k2;
    int seen;
    // R8 reset state
    repeat (3) @(negedge clk);
    chk("R8 pulse low in reset", int'(div_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 pulse low after reset", int'(div_pulse), 0);

    for (int i = 0; i < NV; i++) begin
      load(VEC[i].hi, VEC[i].a, VEC[i].b);
      wait_pulse(k);
      chk("R5 first pulse latency", k, int'(VEC[i].n));
      @(negedge clk);
      chk("R7 pulse one clock wide", int'(div_pulse), 0);
      k2 = 1;
      while (!div_pulse && k2 < 400000) begin
        @(negedge clk);
        k2++;
      end
      chk({vtag[i], " R1 period"}, k2, int'(VEC[i].n));
    end

    // R5 held counter reset
    @(negedge clk);
    cnt_reset = 1'b1;
    mode_hi = 1'b0; swallow_a = 7'd0; main_b = 11'd3;
    seen = 0;
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      if (div_pulse) seen++;
    end
    chk("R5 no pulse while held", seen, 0);
    cnt_reset = 1'b0;
    wait_pulse(k);
    chk("R5 latency after long hold", k, 192);

    // R6 power-down freezes the count
    load(1'b0, 7'd5, 11'd10);
    seen = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (div_pulse) seen++;
    end
    pdn = 1'b1;
    for (int c = 0; c < 800; c++) begin
      @(negedge clk);
      if (div_pulse) seen++;
    end
    chk("R6 no pulse in power-down", seen, 0);
    pdn = 1'b0;
    wait_pulse(k);
    chk("R6 count resumes after power-down", 100 + k, 645);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule